// File: doc/BRIEF.md
# Serial Register Control Port

This block is a slave control port driven by a host over three wires: an active-low select, a serial clock and a serial data input. Each transaction is a fixed 16-bit frame. The host uses it to program a small register file and to read that file back. The register file holds the transceiver control bits: three loopback enables, the polarity of the signal-detect input and the loop bandwidth choice. It also shows live lock and loss-of-signal status, keeps a latched interrupt status register that clears when read, and carries two fixed identification bytes.

The serial pins are oversampled in the block's own clock domain. A serial data output returns read data. An interrupt output is high while any latched status bit that is also enabled is set. Control bits leave the block as plain output ports, and status enters as an input vector. The asynchronous active-low reset clears all writable state.

Top module: `sreg_port`

## Requirements
- R1: A frame is 16 bits sent MSB first, each bit sampled on a rising serial clock edge while select is low. The first bit is the direction flag (1 = read), the next 7 bits are the address, and the last 8 bits are the data.
- R2: Writing address 0x01 sets the control outputs from data bits [4:0]: bit0 digital loopback, bit1 serial remote loopback, bit2 parallel remote loopback, bit3 signal-detect polarity, bit4 loop bandwidth. Writing address 0x02 stores data bits [3:0] as interrupt enables. Bits above those read back as 0.
- R3: In a read frame, the serial data output presents the 8 data bits MSB first. Each bit changes after a falling serial clock edge, so the host samples it at the rising edges of frame bits 9 to 16.
- R4: The serial data output is low outside the data phase of a read frame, including for the whole of every write frame.
- R5: If select rises before the 16th rising edge, the frame is dropped. No register is written and no status is cleared.
- R6: Writes to addresses 0x03, 0x04, 0x7E, 0x7F and to unmapped addresses have no effect. Reads of unmapped addresses return 0x00.
- R7: Address 0x03 returns the live status inputs in bits [3:0]: bit0 transmit lock, bit1 receive lock, bit2 external oscillator lock, bit3 loss of signal.
- R8: Address 0x04 latches a 1 for each rising edge of a status input and holds it after the input falls. A completed read of 0x04 clears only the bits that read returned. An edge that arrives during that read stays latched.
- R9: The interrupt output is high exactly when some latched bit of 0x04 has its enable bit in 0x02 set.
- R10: Address 0x7E reads 0xC0 and address 0x7F reads the revision parameter, which defaults to 0x01.
- R11: While reset is low, the control outputs, the interrupt output and the serial data output are 0. After reset, addresses 0x01, 0x02 and 0x04 read 0x00.
- R12: Serial clock edges beyond the 16th in one select period are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; it oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data to host |
| irq | output | 1 | Interrupt, high while an enabled latched bit is set |
| status_i | input | NSTAT | Live lock and loss-of-signal status |
| dig_lb_o | output | 1 | Digital loopback enable |
| ser_rlb_o | output | 1 | Serial remote loopback enable |
| par_rlb_o | output | 1 | Parallel remote loopback enable |
| sd_pol_o | output | 1 | Signal-detect polarity select |
| lbw_o | output | 1 | Loop bandwidth select |

## Verification
The bench uses the default parameters: two synchronizer stages, four status bits, identification 0xC0 and revision 0x01. The serial clock half period is eight system clocks, which leaves margin over the synchronizer and edge-detect latency before each read bit is sampled. With four status bits, every latched interrupt bit, each combination of enable and latch, and a status edge injected in the middle of a read can all be reached. These cases test the clear-only-what-was-returned rule.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int HDR_W   = 1 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int SH_W    = ((HDR_W > DATA_W) ? HDR_W : DATA_W) - 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 7'h01;
  localparam logic [ADDR_W-1:0] A_IEN   = 7'h02;
  localparam logic [ADDR_W-1:0] A_STAT  = 7'h03;
  localparam logic [ADDR_W-1:0] A_ISTAT = 7'h04;
  localparam logic [ADDR_W-1:0] A_DEVID = 7'h7E;
  localparam logic [ADDR_W-1:0] A_REVID = 7'h7F;

  typedef struct packed {
    logic lbw;
    logic sd_pol;
    logic par_rlb;
    logic ser_rlb;
    logic dig_lb;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sreg_link.sv
module sreg_link
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_stb_o,
  output logic              rd_snap_o,
  output logic              rd_done_o,
  output logic              sdo_o
);
  localparam logic [CNT_W-1:0] C_HDR   = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME_W);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SH_W-1:0]   sh_q, sh_n;
  logic [HDR_W-1:0]  hdr_q, hdr_n;
  logic [DATA_W-2:0] out_q, out_n;
  logic              sdo_q, sdo_n;
  logic              active, rise, fall, take_bit, is_rd;

  assign active    = ~sel_n_i;
  assign rise      = sclk_i & ~sclk_q;
  assign fall      = ~sclk_i & sclk_q;
  assign take_bit  = active & rise & (cnt_q < C_FRAME);
  assign is_rd     = hdr_q[HDR_W-1];
  assign addr_o    = hdr_q[ADDR_W-1:0];
  assign wr_data_o = {sh_q[DATA_W-2:0], sdi_i};
  assign wr_stb_o  = take_bit & (cnt_q == C_LAST) & ~is_rd;
  assign rd_done_o = take_bit & (cnt_q == C_LAST) & is_rd;
  assign rd_snap_o = active & fall & (cnt_q == C_HDR) & is_rd;
  assign sdo_o     = sdo_q;

  always_comb begin
    cnt_n = cnt_q;
    sh_n  = sh_q;
    hdr_n = hdr_q;
    out_n = out_q;
    sdo_n = sdo_q;
    if (!active) begin
      cnt_n = '0;
      sdo_n = 1'b0;
    end else begin
      if (take_bit) begin
        cnt_n = cnt_q + 1'b1;
        sh_n  = {sh_q[SH_W-2:0], sdi_i};
        if (cnt_q == C_HDR - 1'b1) hdr_n = {sh_q[HDR_W-2:0], sdi_i};
      end
      if (rd_snap_o) begin
        out_n = rdata_i[DATA_W-2:0];
        sdo_n = rdata_i[DATA_W-1];
      end else if (fall) begin
        if (is_rd && (cnt_q > C_HDR) && (cnt_q < C_FRAME)) begin
          out_n = {out_q[DATA_W-3:0], 1'b0};
          sdo_n = out_q[DATA_W-2];
        end else begin
          sdo_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      hdr_q  <= '0;
      out_q  <= '0;
      sdo_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      cnt_q  <= cnt_n;
      sdo_q  <= sdo_n;
      if (take_bit)  sh_q  <= sh_n;
      if (take_bit)  hdr_q <= hdr_n;
      if (active)    out_q <= out_n;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= C_FRAME);  // R12
  AST_SDO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_q |-> (is_rd && (cnt_q >= C_HDR)));  // R4
  AST_WR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> ((cnt_q == C_FRAME) || (cnt_q == '0)));  // R1
endmodule

// File: rtl/sreg_regs.sv
module sreg_regs
  import sreg_pkg::*;
#(
  parameter int               NSTAT  = 4,
  parameter logic [DATA_W-1:0] DEV_ID = 8'hC0,
  parameter logic [DATA_W-1:0] REV_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTAT-1:0]  stat_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_stb_i,
  input  logic              rd_snap_i,
  input  logic              rd_done_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q, ctrl_n;
  logic [NSTAT-1:0] ien_q, ien_n;
  logic [NSTAT-1:0] prev_q, rise_ev;
  logic [NSTAT-1:0] ist_q, ist_n;
  logic [NSTAT-1:0] seen_q, seen_n;
  logic             irq_q, irq_n;
  logic             hit_istat;
  logic             unused_wr;

  assign unused_wr = ^wr_data_i;
  assign rise_ev   = stat_i & ~prev_q;
  assign hit_istat = (addr_i == A_ISTAT);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = DATA_W'(ctrl_q);
      A_IEN:   rdata_o = DATA_W'(ien_q);
      A_STAT:  rdata_o = DATA_W'(stat_i);
      A_ISTAT: rdata_o = DATA_W'(ist_q);
      A_DEVID: rdata_o = DEV_ID;
      A_REVID: rdata_o = REV_ID;
      default: rdata_o = '0;
    endcase
  end

  always_comb begin
    ctrl_n = ctrl_q;
    ien_n  = ien_q;
    seen_n = seen_q;
    if (wr_stb_i && addr_i == A_CTRL) ctrl_n = ctrl_t'(wr_data_i[CTRL_W-1:0]);
    if (wr_stb_i && addr_i == A_IEN)  ien_n  = wr_data_i[NSTAT-1:0];
    if (rd_snap_i) seen_n = hit_istat ? ist_q : '0;
    ist_n = (ist_q & ~((rd_done_i && hit_istat) ? seen_q : '0)) | rise_ev;
    irq_n = |(ist_n & ien_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      prev_q <= '0;
      ist_q  <= '0;
      seen_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_stb_i)  ctrl_q <= ctrl_n;
      if (wr_stb_i)  ien_q  <= ien_n;
      if (rd_snap_i) seen_q <= seen_n;
      prev_q <= stat_i;
      ist_q  <= ist_n;
      irq_q  <= irq_n;
    end
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;

  AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(wr_stb_i && (addr_i == A_CTRL)));  // R2
  AST_ISTAT_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ist_q) & ~ist_q)) |-> $past(rd_done_i && hit_istat));  // R8
  AST_ISTAT_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ist_q & ~$past(ist_q))) |-> (|$past(rise_ev)));  // R8
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               NSTAT       = 4,
  parameter logic [DATA_W-1:0] DEV_ID      = 8'hC0,
  parameter logic [DATA_W-1:0] REV_ID      = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             irq,
  input  logic [NSTAT-1:0] status_i,
  output logic             dig_lb_o,
  output logic             ser_rlb_o,
  output logic             par_rlb_o,
  output logic             sd_pol_o,
  output logic             lbw_o
);
  localparam int IN_W = 3 + NSTAT;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [IN_W-1:0]   raw_in, syn_in;
  logic              sel_n_s, sclk_s, sdi_s;
  logic [NSTAT-1:0]  stat_s;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data, rdata;
  logic              wr_stb, rd_snap, rd_done;
  ctrl_t             ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign raw_in = {sel_n, sclk, sdi, status_i};

  if (SYNC_STAGES > 0) begin : g_sync
    sreg_sync #(
      .W       (IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({1'b1, {(IN_W-1){1'b0}}})
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_int_n),
      .d_i   (raw_in),
      .q_o   (syn_in)
    );
  end else begin : g_nosync
    assign syn_in = raw_in;
  end

  assign {sel_n_s, sclk_s, sdi_s, stat_s} = syn_in;

  sreg_link u_link (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel_n_i   (sel_n_s),
    .sclk_i    (sclk_s),
    .sdi_i     (sdi_s),
    .rdata_i   (rdata),
    .addr_o    (addr),
    .wr_data_o (wr_data),
    .wr_stb_o  (wr_stb),
    .rd_snap_o (rd_snap),
    .rd_done_o (rd_done),
    .sdo_o     (sdo)
  );

  sreg_regs #(
    .NSTAT  (NSTAT),
    .DEV_ID (DEV_ID),
    .REV_ID (REV_ID)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .stat_i    (stat_s),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .wr_stb_i  (wr_stb),
    .rd_snap_i (rd_snap),
    .rd_done_i (rd_done),
    .rdata_o   (rdata),
    .ctrl_o    (ctrl),
    .irq_o     (irq)
  );

  assign dig_lb_o  = ctrl.dig_lb;
  assign ser_rlb_o = ctrl.ser_rlb;
  assign par_rlb_o = ctrl.par_rlb;
  assign sd_pol_o  = ctrl.sd_pol;
  assign lbw_o     = ctrl.lbw;
endmodule

// File: tb/tb_sreg_port.sv
`timescale 1ns/1ps
module tb_sreg_port;
  localparam int HALF = 8;
  localparam int NV   = 18;
  // vector fields: {is_read, addr[6:0], wdata[7:0], expected[7:0]}
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 7'h01, 8'hF5, 8'h15},  // R2 control write, upper bits dropped
    {1'b1, 7'h01, 8'h00, 8'h15},  // R3 readback
    {1'b0, 7'h02, 8'hFA, 8'h0A},  // R2 enable write
    {1'b1, 7'h02, 8'h00, 8'h0A},
    {1'b0, 7'h03, 8'hFF, 8'h00},  // R6 read-only
    {1'b1, 7'h03, 8'h00, 8'h00},  // R7 status idle
    {1'b0, 7'h7E, 8'h12, 8'h00},  // R6
    {1'b1, 7'h7E, 8'h00, 8'hC0},  // R10
    {1'b1, 7'h7F, 8'h00, 8'h01},  // R10
    {1'b0, 7'h55, 8'hAA, 8'h00},  // R6 unmapped
    {1'b1, 7'h55, 8'h00, 8'h00},
    {1'b1, 7'h01, 8'h00, 8'h15},
    {1'b0, 7'h01, 8'h0A, 8'h0A},
    {1'b1, 7'h01, 8'h00, 8'h0A},
    {1'b0, 7'h01, 8'h00, 8'h00},
    {1'b1, 7'h02, 8'h00, 8'h0A},
    {1'b0, 7'h04, 8'hFF, 8'h00},  // R6 read-clear register
    {1'b1, 7'h04, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [3:0] status = 4'h0;
  logic sdo, irq, dig_lb, ser_rlb, par_rlb, sd_pol, lbw;
  int   nchk = 0;
  int   nfail = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  sreg_port dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .irq(irq), .status_i(status),
    .dig_lb_o(dig_lb), .ser_rlb_o(ser_rlb), .par_rlb_o(par_rlb),
    .sd_pol_o(sd_pol), .lbw_o(lbw)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrl_pins();
    return {3'b000, lbw, sd_pol, par_rlb, ser_rlb, dig_lb};
  endfunction

  task automatic xfer(input logic rd, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, input logic inj_en, input logic [3:0] inj_val,
                      output logic [7:0] q, output logic sdo_bad);
    logic [15:0] f;
    f = {rd, a, d};
    q = '0;
    sdo_bad = 1'b0;
    sel_n = 1'b0;
    wait_clks(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? f[15-i] : 1'b1;
      wait_clks(HALF);
      if (rd && i >= 8 && i < 16) q = {q[6:0], sdo};
      else if (sdo !== 1'b0) sdo_bad = 1'b1;
      sclk = 1'b1;
      wait_clks(HALF);
      sclk = 1'b0;
      if (inj_en && i == 11) status = inj_val;
    end
    wait_clks(HALF);
    sel_n = 1'b1;
    wait_clks(2*HALF);
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [7:0] q);
    logic bad;
    xfer(1'b1, a, 8'h00, 16, 1'b0, 4'h0, q, bad);
    check("R4 sdo idle during read", {7'h0, bad}, 8'h00);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] q;
    logic bad;
    xfer(1'b0, a, d, 16, 1'b0, 4'h0, q, bad);
    check("R4 sdo low in write", {7'h0, bad}, 8'h00);
  endtask

  initial begin
    logic [7:0] q;
    logic bad;
    wait_clks(5);
    // R11 reset state
    check("R11 ctrl in reset", ctrl_pins(), 8'h00);
    check("R11 irq/sdo in reset", {6'h0, irq, sdo}, 8'h00);
    rst_n = 1'b1;
    wait_clks(10);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][23]) begin
        rd_reg(VEC[v][22:16], q);
        check("R3 vector readback", q, VEC[v][7:0]);  // R1 frame format
      end else begin
        wr_reg(VEC[v][22:16], VEC[v][15:8]);
        if (VEC[v][22:16] == 7'h01) check("R2 ctrl outputs", ctrl_pins(), VEC[v][7:0]);
      end
    end

    // R12 extra clocks ignored
    xfer(1'b0, 7'h01, 8'h03, 24, 1'b0, 4'h0, q, bad);
    check("R12 extra clocks", ctrl_pins(), 8'h03);
    // R5 aborted write
    xfer(1'b0, 7'h01, 8'h1C, 10, 1'b0, 4'h0, q, bad);
    check("R5 aborted write", ctrl_pins(), 8'h03);
    rd_reg(7'h01, q);
    check("R5 ctrl readback", q, 8'h03);

    // R7 live status, R9 enable gating (enables = 0x0A)
    status = 4'b0101;
    wait_clks(10);
    rd_reg(7'h03, q);
    check("R7 status live", q, 8'h05);
    check("R9 irq masked", {7'h0, irq}, 8'h00);
    status = 4'b0111;
    wait_clks(10);
    check("R9 irq enabled bit", {7'h0, irq}, 8'h01);
    rd_reg(7'h04, q);
    check("R8 latched edges", q, 8'h07);
    check("R9 irq after clear", {7'h0, irq}, 8'h00);
    rd_reg(7'h04, q);
    check("R8 cleared by read", q, 8'h00);

    // R8 hold after input falls
    status = 4'b0000; wait_clks(10);
    status = 4'b1000; wait_clks(10);
    status = 4'b0000; wait_clks(10);
    check("R9 irq held", {7'h0, irq}, 8'h01);
    rd_reg(7'h04, q);
    check("R8 held after fall", q, 8'h08);
    check("R9 irq cleared", {7'h0, irq}, 8'h00);

    // R5 aborted read does not clear
    status = 4'b0001; wait_clks(10);
    xfer(1'b1, 7'h04, 8'h00, 12, 1'b0, 4'h0, q, bad);
    rd_reg(7'h04, q);
    check("R5 aborted read kept bits", q, 8'h01);
    rd_reg(7'h04, q);
    check("R8 clear after full read", q, 8'h00);

    // R8 edge during read survives
    status = 4'b0000; wait_clks(10);
    xfer(1'b1, 7'h04, 8'h00, 16, 1'b1, 4'b0100, q, bad);
    check("R8 read before edge", q, 8'h00);
    rd_reg(7'h04, q);
    check("R8 edge during read kept", q, 8'h04);

    // R11 mid-run reset
    wr_reg(7'h01, 8'h1F);
    wr_reg(7'h02, 8'h0F);
    status = 4'b0010; wait_clks(10);
    status = 4'b0000; wait_clks(10);
    check("R9 irq before reset", {7'h0, irq}, 8'h01);
    rst_n = 1'b0;
    wait_clks(2);
    check("R11 ctrl cleared", ctrl_pins(), 8'h00);
    check("R11 irq cleared", {7'h0, irq}, 8'h00);
    rst_n = 1'b1;
    wait_clks(10);
    rd_reg(7'h01, q);
    check("R11 ctrl reg", q, 8'h00);
    rd_reg(7'h02, q);
    check("R11 enable reg", q, 8'h00);
    rd_reg(7'h04, q);
    check("R11 latched reg", q, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule